// File: doc/BRIEF.md
# Byte-Lane Write Memory Core with Compare Register

This block is a synchronous memory array of 18-bit words organised as two 9-bit lanes. On every rising clock edge it samples an address and a set of active-low write controls. A global write stores the whole word. A byte-write gate, when asserted, lets each lane's own enable decide whether that lane is stored. When no lane is written, the cycle is a read, and the addressed word is loaded into an output register.

A separate data-input register captures the write data only when its enable is asserted. On every edge the block compares that register with the word stored at the sampled address and registers the result as a match flag. The compare sees the array contents from before any write made in the same cycle. Two asynchronous active-low enables gate the outputs. One gates the read data and the other gates the match flag, and each has a companion valid flag that stands in for a tri-state driver.

Top module: `bwsram_core`

## Requirements
- R1: When `glob_wr_n` is 0 at a clock edge, all 18 bits of `wdata` are stored at `addr`, whatever the values of `byte_gate_n` and `lane_en_n`.
- R2: When `glob_wr_n` is 1 and `byte_gate_n` is 0, lane i is written from `wdata` if and only if `lane_en_n[i]` is 0. Lane 0 is bits 8:0 and lane 1 is bits 17:9. A lane that is not written keeps its old contents.
- R3: When `glob_wr_n` and `byte_gate_n` are both 1, `lane_en_n` is ignored, nothing is stored, and the cycle is a read.
- R4: On a read cycle, the word stored at `addr` before that edge is loaded into the read register, which is visible on `rdata` after the edge. On a write cycle the read register keeps its value.
- R5: The data-input register loads `wdata` on an edge where `din_en_n` is 0, and holds its value otherwise.
- R6: At each edge the match register is set to 1 if the data-input register (its value before the edge) equals the word stored at `addr` before any write at that edge, and to 0 otherwise.
- R7: `match_valid` equals the inverse of `cmp_en_n`, and `match` is 0 whenever `cmp_en_n` is 1. Both respond to `cmp_en_n` without waiting for a clock edge.
- R8: `rdata_valid` equals the inverse of `out_en_n`, and `rdata` is all zeros whenever `out_en_n` is 1. Both respond to `out_en_n` without waiting for a clock edge.
- R9: A synchronous active-high `rst` clears the array, the read register, the data-input register and the match register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW (8) | Word address |
| glob_wr_n | input | 1 | Whole-word write, active low |
| byte_gate_n | input | 1 | Gate for the per-lane enables, active low |
| lane_en_n | input | 2 | Per-lane write enables, active low; bit 0 = bits 8:0, bit 1 = bits 17:9 |
| din_en_n | input | 1 | Data-input register load enable, active low |
| wdata | input | 18 | Write data |
| out_en_n | input | 1 | Asynchronous read-data output enable, active low |
| cmp_en_n | input | 1 | Asynchronous match output enable, active low |
| rdata | output | 18 | Read data, zero while disabled |
| rdata_valid | output | 1 | Read data is being driven |
| match | output | 1 | Registered compare result, zero while disabled |
| match_valid | output | 1 | Match flag is being driven |

## Verification
The case that is hardest to reach is a compare at an address that is being written in the same cycle. The stored word must differ from the data-input register, while the write brings the two into agreement. The stimulus first loads the data-input register and writes a different value at the address. It then writes the register's value there while comparing at the same edge, and expects a miss followed by a hit on the next edge. Random traffic is kept to sixteen addresses and a pool of four data values, so that matches and partial-lane overwrites happen often.

// File: rtl/bws_pkg.sv
package bws_pkg;
    localparam int LANE_W    = 9;
    localparam int NUM_LANES = 2;
    localparam int WORD_W    = LANE_W * NUM_LANES;

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [LANE_W-1:0]    lane_t;
    typedef logic [NUM_LANES-1:0] lane_mask_t;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_GLOBAL = 2'd1,
        OP_BYTES  = 2'd2
    } op_e;

    typedef struct packed {
        op_e        op;
        lane_mask_t wmask;
    } wr_ctl_t;

    // Whole-word write wins; otherwise lanes act only under the gate.
    function automatic wr_ctl_t decode_write(logic gw_n, logic gate_n, lane_mask_t lane_n);
        wr_ctl_t c;
        if (!gw_n) begin
            c.op    = OP_GLOBAL;
            c.wmask = '1;
        end else if (!gate_n && (~lane_n != '0)) begin
            c.op    = OP_BYTES;
            c.wmask = ~lane_n;
        end else begin
            c.op    = OP_READ;
            c.wmask = '0;
        end
        return c;
    endfunction
endpackage

// File: rtl/bws_wr_decode.sv
module bws_wr_decode
    import bws_pkg::*;
(
    input  logic       glob_wr_n,
    input  logic       byte_gate_n,
    input  lane_mask_t lane_en_n,
    output wr_ctl_t    ctl
);
    always_comb begin
        ctl = decode_write(glob_wr_n, byte_gate_n, lane_en_n);
    end
endmodule

// File: rtl/bws_array.sv
module bws_array
    import bws_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  lane_mask_t    wmask,
    input  word_t         wdata,
    output word_t         rd_word
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        lane_t mem [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wmask[g]) begin
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Combinational read gives the contents before this edge's write.
        assign rd_word[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/bws_din_cmp.sv
module bws_din_cmp
    import bws_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  din_en_n,
    input  word_t wdata,
    input  word_t cur_word,
    output word_t din_q,
    output logic  match_q
);
    logic hit;

    always_comb begin
        hit = (din_q == cur_word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            din_q   <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= hit;
            if (!din_en_n) din_q <= wdata;
        end
    end
endmodule

// File: rtl/bwsram_core.sv
module bwsram_core
    import bws_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        addr,
    input  logic                 glob_wr_n,
    input  logic                 byte_gate_n,
    input  logic [NUM_LANES-1:0] lane_en_n,
    input  logic                 din_en_n,
    input  logic [WORD_W-1:0]    wdata,
    input  logic                 out_en_n,
    input  logic                 cmp_en_n,
    output logic [WORD_W-1:0]    rdata,
    output logic                 rdata_valid,
    output logic                 match,
    output logic                 match_valid
);
    wr_ctl_t ctl;
    word_t   rd_word;
    word_t   rdata_q;
    word_t   din_q;
    logic    match_q;

    bws_wr_decode u_dec (
        .glob_wr_n   (glob_wr_n),
        .byte_gate_n (byte_gate_n),
        .lane_en_n   (lane_en_n),
        .ctl         (ctl)
    );

    bws_array #(.DEPTH(DEPTH)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wmask   (ctl.wmask),
        .wdata   (wdata),
        .rd_word (rd_word)
    );

    bws_din_cmp u_cmp (
        .clk      (clk),
        .rst      (rst),
        .din_en_n (din_en_n),
        .wdata    (wdata),
        .cur_word (rd_word),
        .din_q    (din_q),
        .match_q  (match_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                  rdata_q <= '0;
        else if (ctl.op == OP_READ) rdata_q <= rd_word;
    end

    always_comb begin
        rdata_valid = ~out_en_n;
        rdata       = out_en_n ? '0 : rdata_q;
        match_valid = ~cmp_en_n;
        match       = match_q & ~cmp_en_n;
    end
endmodule

// File: rtl/bws_core_chk.sv
module bws_core_chk
    import bws_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    glob_wr_n,
    input  logic    din_en_n,
    input  logic    out_en_n,
    input  logic    cmp_en_n,
    input  word_t   rdata,
    input  logic    rdata_valid,
    input  logic    match,
    input  logic    match_valid,
    input  wr_ctl_t ctl,
    input  word_t   rdata_q,
    input  word_t   din_q,
    input  logic    match_q
);
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (rdata_q == '0 && din_q == '0 && match_q == 1'b0));

    assert_global_all_lanes_R1: assert property (@(posedge clk) disable iff (rst)
        !glob_wr_n |-> (ctl.wmask == '1));

    assert_write_holds_read_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl.op != OP_READ) |=> $stable(rdata_q));

    assert_din_hold_R5: assert property (@(posedge clk) disable iff (rst)
        din_en_n |=> $stable(din_q));

    assert_match_gate_R7: assert property (@(posedge clk) disable iff (rst)
        cmp_en_n |-> (!match && !match_valid));

    assert_out_gate_R8: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> (rdata == '0 && !rdata_valid));
endmodule

bind bwsram_core bws_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .glob_wr_n   (glob_wr_n),
    .din_en_n    (din_en_n),
    .out_en_n    (out_en_n),
    .cmp_en_n    (cmp_en_n),
    .rdata       (rdata),
    .rdata_valid (rdata_valid),
    .match       (match),
    .match_valid (match_valid),
    .ctl         (ctl),
    .rdata_q     (rdata_q),
    .din_q       (din_q),
    .match_q     (match_q)
);

// File: tb/bwsram_core_tb.sv
`timescale 1ns/1ps
module bwsram_core_tb;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          glob_wr_n, byte_gate_n, din_en_n, out_en_n, cmp_en_n;
    logic [1:0]    lane_en_n;
    logic [17:0]   wdata;
    logic [17:0]   rdata;
    logic          rdata_valid, match, match_valid;

    bwsram_core #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .glob_wr_n(glob_wr_n),
        .byte_gate_n(byte_gate_n), .lane_en_n(lane_en_n), .din_en_n(din_en_n),
        .wdata(wdata), .out_en_n(out_en_n), .cmp_en_n(cmp_en_n),
        .rdata(rdata), .rdata_valid(rdata_valid), .match(match),
        .match_valid(match_valid)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string phase  = "init";

    // Behavioural reference state
    logic [17:0] m_mem [DEPTH];
    logic [17:0] m_din, m_rd;
    logic        m_match;

    task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] act=%h exp=%h at %0t", tag, phase, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        chk("R4 rdata",       out_en_n ? 18'd0 : m_rd, rdata);
        chk("R8 rdata",       {17'd0, rdata_valid}, {17'd0, ~out_en_n});
        chk("R6 match",       {17'd0, match}, {17'd0, m_match & ~cmp_en_n});
        chk("R7 match_valid", {17'd0, match_valid}, {17'd0, ~cmp_en_n});
        if (out_en_n) chk("R8 rdata zero", rdata, 18'd0);
    endtask

    // One clock: drive, predict, step, compare.
    task automatic cyc(logic [AW-1:0] a, logic gw, logic bg, logic [1:0] le,
                       logic de, logic [17:0] wd, logic oe, logic ce);
        logic [17:0] word;
        logic [1:0]  wm;
        addr = a; glob_wr_n = gw; byte_gate_n = bg; lane_en_n = le;
        din_en_n = de; wdata = wd; out_en_n = oe; cmp_en_n = ce;
        word = m_mem[a];
        if (!gw)      wm = 2'b11;
        else if (!bg) wm = ~le;
        else          wm = 2'b00;
        @(posedge clk);
        m_match = (m_din == word);
        if (wm == 2'b00) m_rd = word;
        if (!de) m_din = wd;
        if (wm[0]) m_mem[a][8:0]  = wd[8:0];
        if (wm[1]) m_mem[a][17:9] = wd[17:9];
        #1;
        check_outputs();
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [17:0] wd);
        cyc(a, 1'b0, 1'b1, 2'b11, 1'b1, wd, 1'b0, 1'b0);
    endtask

    task automatic do_read(logic [AW-1:0] a);
        cyc(a, 1'b1, 1'b1, 2'b11, 1'b1, 18'h0, 1'b0, 1'b0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [17:0] pool [4];
        pool[0] = 18'h2A5A5; pool[1] = 18'h15A5A; pool[2] = 18'h3FFFF; pool[3] = 18'h00001;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_din = '0; m_rd = '0; m_match = 1'b0;

        // R9: reset state
        phase = "R9 reset";
        rst = 1'b1; addr = '0; glob_wr_n = 1; byte_gate_n = 1; lane_en_n = 2'b11;
        din_en_n = 1; wdata = 18'h3FFFF; out_en_n = 0; cmp_en_n = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 rdata after reset", rdata, 18'd0);
        chk("R9 match after reset", {17'd0, match}, 18'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1: whole-word write overrides gate and lane enables
        phase = "R1 global";
        cyc(8'd5, 1'b0, 1'b1, 2'b11, 1'b1, 18'h12345, 1'b0, 1'b0);
        cyc(8'd6, 1'b0, 1'b0, 2'b11, 1'b1, 18'h2ABCD, 1'b0, 1'b0);
        do_read(8'd5);
        chk("R1 word 5", rdata, 18'h12345);
        do_read(8'd6);
        chk("R1 word 6", rdata, 18'h2ABCD);

        // R2: per-lane writes under gate
        phase = "R2 lanes";
        do_write(8'd7, 18'h3FFFF);
        cyc(8'd7, 1'b1, 1'b0, 2'b10, 1'b1, 18'h00000, 1'b0, 1'b0);
        do_read(8'd7);
        chk("R2 low lane only", rdata, 18'h3FE00);
        cyc(8'd7, 1'b1, 1'b0, 2'b01, 1'b1, 18'h155AA, 1'b0, 1'b0);
        do_read(8'd7);
        chk("R2 high lane only", rdata, {9'h0AA, 9'h000});

        // R3: lanes ignored while gate high; that cycle is a read
        phase = "R3 gate off";
        cyc(8'd5, 1'b1, 1'b1, 2'b00, 1'b1, 18'h00000, 1'b0, 1'b0);
        chk("R3 read in gated cycle", rdata, 18'h12345);
        do_read(8'd5);
        chk("R3 contents kept", rdata, 18'h12345);

        // R4: read register holds through a write cycle
        phase = "R4 hold";
        do_write(8'd9, 18'h01111);
        chk("R4 held over write", rdata, 18'h12345);

        // R5: data-input register gating
        phase = "R5 din";
        cyc(8'd20, 1'b1, 1'b1, 2'b11, 1'b0, 18'h0BEEF, 1'b0, 1'b0);
        cyc(8'd20, 1'b1, 1'b1, 2'b11, 1'b1, 18'h11111, 1'b0, 1'b0);
        do_write(8'd21, 18'h0BEEF);
        cyc(8'd21, 1'b1, 1'b1, 2'b11, 1'b1, 18'h22222, 1'b0, 1'b0);
        chk("R5 din held -> match", {17'd0, match}, 18'd1);

        // R6: same-cycle write and compare sees old contents
        phase = "R6 same cycle";
        do_write(8'd30, 18'h00777);
        cyc(8'd30, 1'b0, 1'b1, 2'b11, 1'b1, 18'h0BEEF, 1'b0, 1'b0);
        chk("R6 old contents miss", {17'd0, match}, 18'd0);
        do_read(8'd30);
        chk("R6 next cycle hit", {17'd0, match}, 18'd1);

        // R7 / R8: asynchronous gating between edges
        phase = "R7 R8 async";
        @(negedge clk);
        out_en_n = 1'b1; cmp_en_n = 1'b1; #0.5;
        chk("R8 async rdata off", rdata, 18'd0);
        chk("R7 async match off", {17'd0, match, match_valid}, 18'd0);
        out_en_n = 1'b0; cmp_en_n = 1'b0; #0.5;
        chk("R8 async rdata on", rdata, 18'h0BEEF);
        chk("R7 async match on", {17'd0, match_valid}, 18'd1);

        // Random traffic on a small address set and value pool
        phase = "random R1 R2 R3 R4 R5 R6";
        for (int n = 0; n < 2000; n++) begin
            cyc(8'($urandom_range(0, 15)), 1'($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 1)), 2'($urandom),
                1'($urandom_range(0, 2) != 0), pool[$urandom_range(0, 3)],
                1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 4) == 0));
        end

        // R9: reset again clears the array
        phase = "R9 re-reset";
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_din = '0; m_rd = '0; m_match = 1'b0;
        #1;
        chk("R9 rdata cleared", rdata, 18'd0);
        @(negedge clk);
        rst = 1'b0;
        do_read(8'd5);
        chk("R9 array cleared", rdata, 18'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule